// File: doc/BRIEF.md
# NAND Flash Packet Data Engine

This block is the host-facing register front end and packet sequencer of a NAND flash controller. Software programs a packet geometry, then writes a single one-hot bit into a program register to launch a complete flash operation. Page data then moves through one 32-bit data port, one packet at a time. Each packet is opened by its own ready event, and a completion event closes the whole operation. The flash array is modelled by a small internal page store with a fixed busy latency. There is no real pin timing.

Operations fall into three classes:
- **Read class.** Page read, read status, read ID, read parameter page and get feature. The engine waits out the busy latency and then offers packets to be drained.
- **Write class.** Page program and set feature. The engine asks for packets at once and then waits out the busy latency.
- **No-data class.** Erase and reset. The engine only waits out the busy latency.

Five interrupt causes feed a status register. Each cause latches only when its status-enable bit is set, and software clears it by writing a 1. The interrupt line is gated by a separate signal-enable register. An external multi-bit error strobe stands in for the ECC checker.

Top module: `nfc_pkt_engine`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The plain configuration registers read back exactly what was written: packet 0x00, address one 0x04, address two 0x08, command 0x0C, ECC setup 0x34 and interface timing 0x6C. Status enable (0x14) and signal enable (0x18) keep bits 4:0. The program register (0x10) reads zero.
- R3: The interrupt status at 0x1C uses these bits: write-ready = bit 0, read-ready = bit 1, transfer-done = bit 2, multi-bit error = bit 3, error = bit 4. Writing a 1 to a status bit clears it.
- R4: A status bit latches only while its status-enable bit is set. `irq` is high exactly when some status bit is set whose signal-enable bit is also set.
- R5: Packet geometry comes from the packet register: bytes per packet in bits 10:0 (words = bytes/4) and packet count in bits 23:12. A page read (program bit 0) raises read-ready after BUSY_CYCLES, and raises it again for each further packet. Its words come from page store positions 0,1,2,…, and transfer-done rises on the last word of the last packet.
- R6: A page program (program bit 4) raises write-ready at once for each packet and stores the pushed words at positions 0,1,2,…. Transfer-done follows BUSY_CYCLES after the last word.
- R7: Erase (program bit 2) sets every page word to 0xFFFFFFFF and then signals transfer-done. Reset (program bit 8) only signals transfer-done and leaves the page unchanged.
- R8: A data-port read with no read packet open returns zero and does not advance the word position. A data-port write with no write packet open is ignored.
- R9: A nonzero program write raises the error bit and starts nothing in any of these cases: the engine is busy; the value is not one-hot; the value uses an unassigned bit; or it requests a data operation with zero words or zero packets.
- R10: Read status (bit 3) returns 0x00000040 for every word. Read ID (bit 6), read parameter page (bit 7) and get feature (bit 9) stream the page store like a page read. Set feature (bit 10) takes its packets without changing the page store.
- R11: `mbitErrIn` high during a read-class operation, in either its busy phase or its drain phase, sets status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a data-port read pops a word on this edge |
| regAddr | input | ADDR_W | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the same cycle as `regAddr` |
| mbitErrIn | input | 1 | Multi-bit ECC error strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that reads and writes never share a cycle. They also assume that `regAddr` stays stable while a strobe is high, so that a data-port read with nothing open leaves the word position unchanged. The stimulus keeps to this by issuing exactly one access per task call, each held for a single clock with an idle cycle between accesses. Packet geometry is kept small, with at most eight words per packet and four packets, so that random program/read-back runs stay within the page store.

// File: rtl/nfc_pkt_pkg.sv
`timescale 1ns/1ps
package nfc_pkt_pkg;
  localparam int REG_W  = 32;
  localparam int IRQ_W  = 5;
  localparam int PROG_W = 11;

  // register offsets
  localparam logic [7:0] OFS_PKT   = 8'h00;
  localparam logic [7:0] OFS_ADR1  = 8'h04;
  localparam logic [7:0] OFS_ADR2  = 8'h08;
  localparam logic [7:0] OFS_CMD   = 8'h0C;
  localparam logic [7:0] OFS_PROG  = 8'h10;
  localparam logic [7:0] OFS_STSEN = 8'h14;
  localparam logic [7:0] OFS_SIGEN = 8'h18;
  localparam logic [7:0] OFS_STS   = 8'h1C;
  localparam logic [7:0] OFS_DATA  = 8'h30;
  localparam logic [7:0] OFS_ECC   = 8'h34;
  localparam logic [7:0] OFS_TIMG  = 8'h6C;

  // interrupt cause positions
  localparam int EV_WRRDY = 0;
  localparam int EV_RDRDY = 1;
  localparam int EV_DONE  = 2;
  localparam int EV_MBIT  = 3;
  localparam int EV_ERR   = 4;

  // program trigger positions
  localparam int OP_PGRD  = 0;
  localparam int OP_ERASE = 2;
  localparam int OP_STAT  = 3;
  localparam int OP_PGPRG = 4;
  localparam int OP_RDID  = 6;
  localparam int OP_PARAM = 7;
  localparam int OP_RST   = 8;
  localparam int OP_GETF  = 9;
  localparam int OP_SETF  = 10;

  localparam logic [PROG_W-1:0] ONE = PROG_W'(1);
  localparam logic [PROG_W-1:0] OPS_READ  = (ONE << OP_PGRD) | (ONE << OP_STAT) |
                                            (ONE << OP_RDID) | (ONE << OP_PARAM) |
                                            (ONE << OP_GETF);
  localparam logic [PROG_W-1:0] OPS_WRITE = (ONE << OP_PGPRG) | (ONE << OP_SETF);
  localparam logic [PROG_W-1:0] OPS_NODAT = (ONE << OP_ERASE) | (ONE << OP_RST);
  localparam logic [PROG_W-1:0] OPS_LEGAL = OPS_READ | OPS_WRITE | OPS_NODAT;

  localparam logic [REG_W-1:0] STATUS_WORD = 32'h0000_0040;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_RDPKT, ST_WRPKT, ST_POST
  } engState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ptrClear;
    logic ptrInc;
    logic storeWr;
    logic eraseAll;
    logic rdLive;
    logic statusPat;
  } dpStrobe_t;
endpackage

// File: rtl/nfc_pkt_dpath.sv
`timescale 1ns/1ps
module nfc_pkt_dpath
  import nfc_pkt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_WORDS = 64,
  parameter int PKT_SIZE_W = 11,
  parameter int PKT_CNT_W  = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      regWdata,
  input  dpStrobe_t             strobe,
  input  logic [IRQ_W-1:0]      stsEn,
  input  logic [IRQ_W-1:0]      sigEn,
  input  logic [IRQ_W-1:0]      sts,
  output logic [REG_W-1:0]      regRdata,
  output logic [PKT_SIZE_W-3:0] pktWords,
  output logic [PKT_CNT_W-1:0]  pktCount,
  output logic [$clog2(PAGE_WORDS)-1:0] ptr
);
  localparam int PTR_W   = $clog2(PAGE_WORDS);
  localparam int NCFG    = 6;
  localparam int CNT_LSB = 12;

  function automatic logic [ADDR_W-1:0] cfgOfs(input int idx);
    case (idx)
      0:       return ADDR_W'(OFS_PKT);
      1:       return ADDR_W'(OFS_ADR1);
      2:       return ADDR_W'(OFS_ADR2);
      3:       return ADDR_W'(OFS_CMD);
      4:       return ADDR_W'(OFS_ECC);
      default: return ADDR_W'(OFS_TIMG);
    endcase
  endfunction

  logic [REG_W-1:0] cfg   [NCFG];
  logic [REG_W-1:0] store [PAGE_WORDS];

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN)                                 cfg[g] <= '0;
      else if (regWrEn && regAddr == cfgOfs(g))  cfg[g] <= regWdata;
    end
  end

  assign pktWords = cfg[0][PKT_SIZE_W-1:2];
  assign pktCount = cfg[0][CNT_LSB +: PKT_CNT_W];

  always_ff @(posedge clk) begin
    if (!rstN)                ptr <= '0;
    else if (strobe.ptrClear) ptr <= '0;
    else if (strobe.ptrInc)   ptr <= ptr + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAGE_WORDS; i++) store[i] <= '0;
    end else if (strobe.eraseAll) begin
      for (int i = 0; i < PAGE_WORDS; i++) store[i] <= '1;
    end else if (strobe.storeWr) begin
      store[ptr] <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NCFG; i++)
      if (regAddr == cfgOfs(i)) regRdata = cfg[i];
    if (regAddr == ADDR_W'(OFS_STSEN)) regRdata = REG_W'(stsEn);
    if (regAddr == ADDR_W'(OFS_SIGEN)) regRdata = REG_W'(sigEn);
    if (regAddr == ADDR_W'(OFS_STS))   regRdata = REG_W'(sts);
    if (regAddr == ADDR_W'(OFS_DATA) && strobe.rdLive)
      regRdata = strobe.statusPat ? STATUS_WORD : store[ptr];
  end
endmodule

// File: rtl/nfc_pkt_ctrl.sv
`timescale 1ns/1ps
module nfc_pkt_ctrl
  import nfc_pkt_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 6,
  parameter int WORD_W      = 9,
  parameter int PKT_CNT_W   = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWdata,
  input  logic                 mbitErrIn,
  input  logic [WORD_W-1:0]    pktWords,
  input  logic [PKT_CNT_W-1:0] pktCount,
  output dpStrobe_t            strobe,
  output logic [IRQ_W-1:0]     stsEn,
  output logic [IRQ_W-1:0]     sigEn,
  output logic [IRQ_W-1:0]     sts,
  output logic                 irq,
  output logic                 engIdle
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(BUSY_CYCLES - 1);

  engState_e            state, stateN;
  logic [PROG_W-1:0]    op, opN;
  logic [BUSY_W-1:0]    busy, busyN;
  logic [WORD_W-1:0]    words, wordsN, wordCnt, wordCntN;
  logic [PKT_CNT_W-1:0] left, leftN;
  logic [IRQ_W-1:0]     ev, w1c;

  logic              hitProg, hitData, dpRd, dpWr, upperSet, dataOp;
  logic              progValid, progStart, progErr, lastWord, lastPkt;
  logic [PROG_W-1:0] progVal;

  assign hitProg  = regWrEn && regAddr == ADDR_W'(OFS_PROG);
  assign hitData  = regAddr == ADDR_W'(OFS_DATA);
  assign progVal  = regWdata[PROG_W-1:0];
  assign upperSet = |regWdata[REG_W-1:PROG_W];
  assign dataOp   = |(progVal & (OPS_READ | OPS_WRITE));

  assign progValid = !upperSet && $onehot(progVal) && ((progVal & ~OPS_LEGAL) == '0) &&
                     (!dataOp || (pktWords != '0 && pktCount != '0));
  assign progStart = hitProg && state == ST_IDLE && progValid;
  assign progErr   = hitProg && regWdata != '0 && (state != ST_IDLE || !progValid);

  assign dpRd     = regRdEn && hitData && state == ST_RDPKT;
  assign dpWr     = regWrEn && hitData && state == ST_WRPKT;
  assign lastWord = wordCnt == words - WORD_W'(1);
  assign lastPkt  = left == PKT_CNT_W'(1);

  always_comb begin
    stateN   = state;
    opN      = op;
    busyN    = busy;
    wordsN   = words;
    wordCntN = wordCnt;
    leftN    = left;
    ev       = '0;
    strobe   = '0;
    unique case (state)
      ST_IDLE: if (progStart) begin
        opN      = progVal;
        wordsN   = pktWords;
        leftN    = pktCount;
        wordCntN = '0;
        if (|(progVal & OPS_READ)) begin
          stateN = ST_PRE;
          busyN  = BUSY_LOAD;
        end else if (|(progVal & OPS_WRITE)) begin
          stateN        = ST_WRPKT;
          ev[EV_WRRDY]  = 1'b1;
        end else begin
          stateN = ST_POST;
          busyN  = BUSY_LOAD;
        end
      end
      ST_PRE: begin
        if (busy == '0) begin
          stateN       = ST_RDPKT;
          ev[EV_RDRDY] = 1'b1;
        end else busyN = busy - BUSY_W'(1);
      end
      ST_RDPKT: if (dpRd) begin
        if (!lastWord) wordCntN = wordCnt + WORD_W'(1);
        else if (lastPkt) begin
          stateN      = ST_IDLE;
          ev[EV_DONE] = 1'b1;
        end else begin
          leftN        = left - PKT_CNT_W'(1);
          wordCntN     = '0;
          ev[EV_RDRDY] = 1'b1;
        end
      end
      ST_WRPKT: if (dpWr) begin
        if (!lastWord) wordCntN = wordCnt + WORD_W'(1);
        else if (lastPkt) begin
          stateN = ST_POST;
          busyN  = BUSY_LOAD;
        end else begin
          leftN        = left - PKT_CNT_W'(1);
          wordCntN     = '0;
          ev[EV_WRRDY] = 1'b1;
        end
      end
      ST_POST: begin
        if (busy == '0) begin
          stateN          = ST_IDLE;
          ev[EV_DONE]     = 1'b1;
          strobe.eraseAll = op[OP_ERASE];
        end else busyN = busy - BUSY_W'(1);
      end
      default: stateN = ST_IDLE;
    endcase
    ev[EV_MBIT]      = mbitErrIn && (state == ST_PRE || state == ST_RDPKT);
    ev[EV_ERR]       = progErr;
    strobe.ptrClear  = progStart;
    strobe.ptrInc    = dpRd || dpWr;
    strobe.storeWr   = dpWr && op[OP_PGPRG];
    strobe.rdLive    = state == ST_RDPKT;
    strobe.statusPat = op[OP_STAT];
  end

  assign w1c = (regWrEn && regAddr == ADDR_W'(OFS_STS)) ? regWdata[IRQ_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      op      <= '0;
      busy    <= '0;
      words   <= '0;
      wordCnt <= '0;
      left    <= '0;
      sts     <= '0;
      stsEn   <= '0;
      sigEn   <= '0;
    end else begin
      state   <= stateN;
      op      <= opN;
      busy    <= busyN;
      words   <= wordsN;
      wordCnt <= wordCntN;
      left    <= leftN;
      sts     <= (sts & ~w1c) | (ev & stsEn);
      if (regWrEn && regAddr == ADDR_W'(OFS_STSEN)) stsEn <= regWdata[IRQ_W-1:0];
      if (regWrEn && regAddr == ADDR_W'(OFS_SIGEN)) sigEn <= regWdata[IRQ_W-1:0];
    end
  end

  assign irq     = |(sts & sigEn);
  assign engIdle = state == ST_IDLE;
endmodule

// File: rtl/nfc_pkt_engine.sv
`timescale 1ns/1ps
module nfc_pkt_engine
  import nfc_pkt_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_WORDS  = 64,
  parameter int BUSY_CYCLES = 6,
  parameter int PKT_SIZE_W  = 11,
  parameter int PKT_CNT_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              mbitErrIn,
  output logic              irq
);
  localparam int WORD_W = PKT_SIZE_W - 2;
  localparam int PTR_W  = $clog2(PAGE_WORDS);

  dpStrobe_t            strobe;
  logic [IRQ_W-1:0]     stsEn, sigEn, sts;
  logic [WORD_W-1:0]    pktWords;
  logic [PKT_CNT_W-1:0] pktCount;
  logic [PTR_W-1:0]     ptr;
  logic                 engIdle;

  nfc_pkt_ctrl #(
    .ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES), .WORD_W(WORD_W), .PKT_CNT_W(PKT_CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .mbitErrIn(mbitErrIn), .pktWords(pktWords), .pktCount(pktCount),
    .strobe(strobe), .stsEn(stsEn), .sigEn(sigEn), .sts(sts), .irq(irq), .engIdle(engIdle)
  );

  nfc_pkt_dpath #(
    .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS), .PKT_SIZE_W(PKT_SIZE_W), .PKT_CNT_W(PKT_CNT_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
    .strobe(strobe), .stsEn(stsEn), .sigEn(sigEn), .sts(sts), .regRdata(regRdata),
    .pktWords(pktWords), .pktCount(pktCount), .ptr(ptr)
  );
endmodule

// File: rtl/nfc_pkt_checker.sv
`timescale 1ns/1ps
module nfc_pkt_checker
  import nfc_pkt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic [IRQ_W-1:0]  stsEn,
  input logic [IRQ_W-1:0]  sts,
  input logic              rdLive,
  input logic [PTR_W-1:0]  ptr,
  input logic              engIdle
);
  logic dataRd, progWr;
  assign dataRd = regRdEn && !regWrEn && regAddr == ADDR_W'(OFS_DATA);
  assign progWr = regWrEn && regAddr == ADDR_W'(OFS_PROG) && regWdata != '0;

  p_enable_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sts & ~$past(sts) & ~$past(stsEn)) == '0);

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataRd && !rdLive |-> regRdata == '0);

  p_hold_ptr_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataRd && !rdLive |=> $stable(ptr));

  p_busy_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    progWr && !engIdle && stsEn[EV_ERR] |=> sts[EV_ERR]);

  p_bad_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    progWr && !$onehot(regWdata) && stsEn[EV_ERR] |=> sts[EV_ERR] && engIdle);
endmodule

bind nfc_pkt_engine nfc_pkt_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .stsEn(stsEn), .sts(sts),
  .rdLive(strobe.rdLive), .ptr(ptr), .engIdle(engIdle)
);

// File: tb/sim_nfc_pkt_engine.sv
`timescale 1ns/1ps
module sim_nfc_pkt_engine;
  localparam logic [7:0] A_PKT = 8'h00, A_AD1 = 8'h04, A_AD2 = 8'h08, A_CMD = 8'h0C;
  localparam logic [7:0] A_PRG = 8'h10, A_SEN = 8'h14, A_GEN = 8'h18, A_STS = 8'h1C;
  localparam logic [7:0] A_DAT = 8'h30, A_ECC = 8'h34, A_TIM = 8'h6C;

  logic clk = 0, rstN = 0, regWrEn = 0, regRdEn = 0, mbitErrIn = 0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic irq;

  int nChk = 0, nFail = 0, cyc = 0;
  logic [31:0] model [64];

  nfc_pkt_engine u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mbitErrIn(mbitErrIn), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic waitBit(input int b, output bit seen);
    logic [31:0] v;
    seen = 0;
    for (int k = 0; k < 100 && !seen; k++) begin
      rd(A_STS, v);
      if (v[b]) seen = 1;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [31:0] geom(input int w, input int c);
    return 32'(c << 12) | 32'(w * 4);
  endfunction

  // write-class operation: opb 4 stores, opb 10 does not (R6, R10)
  task automatic pushOp(input int w, input int c, input int opb, input string req);
    bit seen;
    int idx = 0;
    logic [31:0] d;
    wr(A_PKT, geom(w, c));
    wr(A_PRG, 32'(1) << opb);
    for (int p = 0; p < c; p++) begin
      waitBit(0, seen);
      check(seen, {req, " write-ready"}, 32'(seen), 1);
      wr(A_STS, 32'h1);
      for (int i = 0; i < w; i++) begin
        d = $urandom;
        if (opb == 4) model[idx % 64] = d;
        wr(A_DAT, d);
        idx++;
      end
    end
    waitBit(2, seen);
    check(seen, {req, " done after push"}, 32'(seen), 1);
    wr(A_STS, 32'h5);
  endtask

  // read-class operation, compares each word (R5, R10)
  task automatic pullOp(input int w, input int c, input int opb, input bit probe, input string req);
    bit seen;
    int idx = 0;
    logic [31:0] d, e;
    wr(A_PKT, geom(w, c));
    wr(A_PRG, 32'(1) << opb);
    if (probe) begin
      rd(A_DAT, d);
      check(d == 0, "R8 data read while busy", d, 0);
    end
    for (int p = 0; p < c; p++) begin
      waitBit(1, seen);
      check(seen, {req, " read-ready"}, 32'(seen), 1);
      wr(A_STS, 32'h2);
      for (int i = 0; i < w; i++) begin
        rd(A_DAT, d);
        e = (opb == 3) ? 32'h40 : model[idx % 64];
        check(d == e, {req, " data word"}, d, e);
        idx++;
      end
    end
    waitBit(2, seen);
    check(seen, {req, " done after drain"}, 32'(seen), 1);
    wr(A_STS, 32'h6);
  endtask

  task automatic noData(input int opb);
    wr(A_PRG, 32'(1) << opb);
  endtask

  initial begin
    logic [31:0] v, x;
    bit seen;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) model[i] = '0;
    idle(3);
    rstN = 1;
    idle(1);

    // R1
    rd(A_STS, v); check(v == 0, "R1 status after reset", v, 0);
    rd(A_PKT, v); check(v == 0, "R1 packet reg after reset", v, 0);
    check(irq == 0, "R1 irq after reset", 32'(irq), 0);

    // R2
    begin
      logic [7:0] al [6] = '{A_PKT, A_AD1, A_AD2, A_CMD, A_ECC, A_TIM};
      for (int i = 0; i < 6; i++) begin
        x = $urandom;
        wr(al[i], x); rd(al[i], v);
        check(v == x, "R2 config readback", v, x);
      end
    end
    wr(A_SEN, 32'hFFFF_FFFF); rd(A_SEN, v); check(v == 32'h1F, "R2 status enable width", v, 32'h1F);
    wr(A_GEN, 32'h0000_0003); rd(A_GEN, v); check(v == 32'h3, "R2 signal enable readback", v, 3);
    rd(A_PRG, v); check(v == 0, "R2 program reads zero", v, 0);
    wr(A_GEN, 0);

    // R6 then R5 directed, 4 words x 4 packets, probe R8 in busy phase
    pushOp(4, 4, 4, "R6");
    pullOp(4, 4, 0, 1, "R5");

    // R8: stray data write in idle ignored, stray read returns zero
    wr(A_DAT, 32'hDEAD_BEEF);
    rd(A_DAT, v); check(v == 0, "R8 idle data read", v, 0);
    pullOp(2, 1, 0, 0, "R8 page unchanged");

    // random program/readback
    for (int it = 0; it < 6; it++) begin
      int w = 1 + int'($urandom % 8);
      int c = 1 + int'($urandom % 4);
      pushOp(w, c, 4, "R6 random");
      pullOp(w, c, 0, 0, "R5 random");
    end

    // R3: write-one-to-clear leaves other bits
    wr(A_PRG, 32'h3);
    noData(8);
    waitBit(2, seen);
    rd(A_STS, v); check(v[4] && v[2], "R3 err and done both set", v, 32'h14);
    wr(A_STS, 32'h4);
    rd(A_STS, v); check(v == 32'h10, "R3 clear of one bit only", v, 32'h10);
    wr(A_STS, 32'h10);

    // R4 gating and irq
    wr(A_SEN, 32'h1B);
    noData(8); idle(20);
    rd(A_STS, v); check(v[2] == 0, "R4 disabled cause stays low", v, 0);
    wr(A_SEN, 32'h1F);
    wr(A_GEN, 32'h4);
    check(irq == 0, "R4 irq low before event", 32'(irq), 0);
    noData(8);
    waitBit(2, seen);
    check(irq == 1, "R4 irq on enabled cause", 32'(irq), 1);
    wr(A_STS, 32'h4);
    check(irq == 0, "R4 irq after clear", 32'(irq), 0);
    wr(A_GEN, 0);

    // R9 busy, non-one-hot, unassigned bit, zero geometry
    noData(8);
    wr(A_PRG, 32'h1);
    rd(A_STS, v); check(v[4] == 1, "R9 program while busy", v, 32'h10);
    waitBit(2, seen);
    wr(A_STS, 32'h1F);
    idle(20);
    rd(A_STS, v); check(v == 0, "R9 busy request did not start", v, 0);
    wr(A_PRG, 32'h11); idle(20);
    rd(A_STS, v); check(v == 32'h10, "R9 non-one-hot rejected", v, 32'h10);
    wr(A_STS, 32'h1F);
    wr(A_PRG, 32'h20); idle(20);
    rd(A_STS, v); check(v == 32'h10, "R9 unassigned bit rejected", v, 32'h10);
    wr(A_STS, 32'h1F);
    wr(A_PKT, 32'h0000_0010);
    wr(A_PRG, 32'h1); idle(20);
    rd(A_STS, v); check(v == 32'h10, "R9 zero packet count rejected", v, 32'h10);
    wr(A_STS, 32'h1F);

    // R10 status pattern, id stream, set feature leaves page
    pullOp(3, 1, 3, 0, "R10 status");
    pushOp(2, 1, 10, "R10 setfeature");
    pullOp(4, 2, 6, 0, "R10 read id");

    // R11 multi-bit error during busy phase
    wr(A_PKT, geom(2, 1));
    wr(A_PRG, 32'h1);
    @(negedge clk); mbitErrIn = 1;
    @(negedge clk); mbitErrIn = 0;
    rd(A_STS, v); check(v[3] == 1, "R11 multi-bit flag", v, 32'h8);
    waitBit(1, seen);
    rd(A_DAT, v); check(v == model[0], "R11 drain word0", v, model[0]);
    rd(A_DAT, v); check(v == model[1], "R11 drain word1", v, model[1]);
    waitBit(2, seen);
    wr(A_STS, 32'h1F);

    // R7 reset keeps page, erase fills ones
    noData(8); waitBit(2, seen); wr(A_STS, 32'h4);
    pullOp(4, 1, 0, 0, "R7 after reset op");
    noData(2); waitBit(2, seen);
    check(seen, "R7 erase done", 32'(seen), 1);
    wr(A_STS, 32'h4);
    for (int i = 0; i < 64; i++) model[i] = 32'hFFFF_FFFF;
    pullOp(4, 2, 0, 0, "R7 erased page");

    summary();
    $finish;
  end
endmodule